// File: doc/BRIEF.md
# Multi-phase memory self-test engine

This block is a hardware controller that tests a byte-wide RAM between a start address and an end address, both inclusive. After a start strobe it runs a fixed series of phases and drives the RAM's address, write data and write enable itself. The phases are a stuck-bit phase, a walking-one phase, an address-line phase with a marker byte that moves by powers of two, and a pseudo-random pattern phase. Every readback is compared against the value the engine expects.

When a byte read back differs from the expected byte, the engine reports the location, the expected byte and the byte it read, then pauses until the host acknowledges the report. After the first three phases it keeps running random passes until the abort input is asserted, and it counts the passes. A random-only mode skips the first three phases. The RAM read port is combinational: the byte at `mem_addr` is present on `rd_data` in the same cycle.

Top module: `memtest_engine`

## Requirements
- R1: After reset, and until a start strobe is taken while idle, `busy`, `mem_we` and `err_valid` are 0 and `pass_count` is 0. A start resets `pass_count` to 0.
- R2: The stuck-bit phase writes FFh to every address from start to end in ascending order and reads them back. It then does the same with 00h.
- R3: The walking-one phase runs eight fill/readback sweeps with patterns 01h, 02h, 04h and so on up to 80h, in that order.
- R4: The address-line phase first fills the range with the background byte. With offset 0 it then repeats three steps: write the marker at start+offset, read back the whole range (the marker is expected at start+offset and the background everywhere else), and write the background at start+offset. The next offset is 1 after 0 and doubles after that. The walk ends when start+offset, computed one bit wider than the address, is greater than end.
- R5: The address-line phase runs twice. The first run uses background 55h and marker AAh. The second uses background AAh and marker 55h.
- R6: A random pass fills the range with successive states of an 8-bit LFSR. The next state is (s<<1) | parity(s & B8h). The pass then reloads the same seed and reads back the same sequence. The first seed after start is A5h. Each later seed is the LFSR state after the last address of the previous readback, with 00h replaced by 01h. `pass_count` increments by one at the end of each readback. Random passes repeat without end.
- R7: When a readback byte differs from the expected byte, `err_valid` pulses for one cycle. `err_addr`, `err_expected` and `err_actual` hold the location, the expected byte and the byte read. The engine then makes no writes and holds its address until `err_continue` is sampled high, and then it resumes at the next address.
- R8: When `abort` is sampled high in any state, `busy` and `mem_we` are 0 from the next cycle on, and no write occurs until the next start.
- R9: With `rand_only` high at start, the engine goes straight to the random phase, so its first write is A5h at the start address.
- R10: The RAM is written at a rising edge while `mem_we` is 1. While busy, `mem_addr` stays within start..end. `mem_we` is 1 only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, taken when idle |
| abort | input | 1 | Stop the test and return to idle |
| rand_only | input | 1 | At start: run only the random phase |
| start_addr | input | ADDR_W | First address tested |
| end_addr | input | ADDR_W | Last address tested (inclusive, not below start) |
| rd_data | input | 8 | RAM byte at mem_addr, same cycle |
| err_continue | input | 1 | Acknowledge a report and resume |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| busy | output | 1 | Test running |
| err_valid | output | 1 | One-cycle pulse: a mismatch has been reported |
| err_addr | output | ADDR_W | Address of the last mismatch |
| err_expected | output | 8 | Expected byte of the last mismatch |
| err_actual | output | 8 | Byte read at the last mismatch |
| pass_count | output | PASS_W | Completed random passes since start |

## Verification
A wrong phase, sub-step, offset or LFSR state shows on the write port within one cycle, because every write is compared in order against a model of the complete sequence. A wrong compare value shows at the next readback: either a false report on a good RAM, or a missing or wrong report on a RAM with an injected stuck bit. A wrong end-of-walk decision shows as an extra or missing marker write at the end of the address-line walk, and a wrong seed update shows in the first write of the following random pass.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    PH_STUCK = 2'd0,
    PH_WALK1 = 2'd1,
    PH_ADDR  = 2'd2,
    PH_RAND  = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FILL   = 3'd1,
    ST_MARK   = 3'd2,
    ST_VERIFY = 3'd3,
    ST_HOLD   = 3'd4,
    ST_CLEAR  = 3'd5
  } state_t;

  // Fibonacci LFSR for x^8+x^6+x^5+x^4+1
  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] seed_fix(input logic [7:0] s);
    return (s == 8'h00) ? 8'h01 : s;
  endfunction

  // background byte for a phase and its sub-step
  function automatic logic [7:0] bg_byte(input phase_t ph, input logic [2:0] sub);
    case (ph)
      PH_STUCK: return sub[0] ? 8'h00 : 8'hFF;
      PH_WALK1: return 8'h01 << sub;
      PH_ADDR:  return sub[0] ? 8'hAA : 8'h55;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] marker_byte(input logic [2:0] sub);
    return sub[0] ? 8'h55 : 8'hAA;
  endfunction

endpackage

// File: rtl/mt_sweep.sv
module mt_sweep #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  assign at_last = (addr == last_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= first_addr;
    else if (adv)  addr <= addr + AW'(1);
  end
endmodule

// File: rtl/mt_lfsr.sv
module mt_lfsr
  import memtest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  output logic [7:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= 8'h01;
    else if (load) state <= load_val;
    else if (step) state <= lfsr_next(state);
  end
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import memtest_pkg::*;
#(
  parameter int         AW     = 8,
  parameter int         PW     = 16,
  parameter logic [7:0] SEED0  = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          rand_only,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic [7:0]    rd_data,
  input  logic          err_continue,
  input  logic [AW-1:0] sweep_addr,
  input  logic          sweep_last,
  input  logic [7:0]    lfsr_q,
  output logic          sweep_load,
  output logic          sweep_adv,
  output logic          lfsr_load,
  output logic [7:0]    lfsr_seed,
  output logic          lfsr_step,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          busy,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [7:0]    err_expected,
  output logic [7:0]    err_actual,
  output logic [PW-1:0] pass_count,
  output logic          pass_done,
  output logic          mismatch
);
  localparam int OW = AW + 1;

  state_t      state;
  phase_t      phase;
  logic [2:0]  sub;
  logic [OW-1:0] offset;
  logic [7:0]  seed;

  logic [OW-1:0] mark_addr, next_off, next_mark;
  logic          walk_done, start_go, adv_ok, verify_end;
  logic [7:0]    bg, mk, exp_val;

  assign start_go  = (state == ST_IDLE) && start && !abort;
  assign bg        = bg_byte(phase, sub);
  assign mk        = marker_byte(sub);
  assign mark_addr = {1'b0, start_addr} + offset;
  assign next_off  = (offset == '0) ? OW'(1) : (offset << 1);
  assign next_mark = {1'b0, start_addr} + next_off;
  assign walk_done = next_mark > {1'b0, end_addr};

  always_comb begin
    if (phase == PH_RAND)
      exp_val = lfsr_q;
    else if (phase == PH_ADDR && {1'b0, sweep_addr} == mark_addr)
      exp_val = mk;
    else
      exp_val = bg;
  end

  assign mismatch   = (state == ST_VERIFY) && (rd_data != exp_val);
  assign adv_ok     = ((state == ST_VERIFY) && !mismatch) ||
                      ((state == ST_HOLD) && err_continue);
  assign verify_end = adv_ok && sweep_last && !abort;
  assign pass_done  = verify_end && (phase == PH_RAND);

  // RAM port
  assign mem_addr  = (state == ST_MARK || state == ST_CLEAR) ? mark_addr[AW-1:0]
                                                              : sweep_addr;
  always_comb begin
    case (state)
      ST_MARK:  mem_wdata = mk;
      ST_CLEAR: mem_wdata = bg;
      default:  mem_wdata = (phase == PH_RAND) ? lfsr_q : bg;
    endcase
  end
  assign mem_we = (state == ST_FILL) || (state == ST_MARK) || (state == ST_CLEAR);
  assign busy   = (state != ST_IDLE);

  // sweep and pattern generator control
  assign sweep_adv  = ((state == ST_FILL) || adv_ok) && !sweep_last;
  assign sweep_load = start_go || (((state == ST_FILL) || adv_ok) && sweep_last);
  assign lfsr_step  = (phase == PH_RAND) && ((state == ST_FILL) || adv_ok);

  always_comb begin
    lfsr_load = 1'b0;
    lfsr_seed = seed;
    if (start_go) begin
      lfsr_load = 1'b1;
      lfsr_seed = SEED0;
    end else if (phase == PH_RAND && state == ST_FILL && sweep_last) begin
      lfsr_load = 1'b1;
    end else if (pass_done) begin
      lfsr_load = 1'b1;
      lfsr_seed = seed_fix(lfsr_next(lfsr_q));
    end else if (state == ST_CLEAR && walk_done && sub[0]) begin
      lfsr_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      phase        <= PH_STUCK;
      sub          <= '0;
      offset       <= '0;
      seed         <= SEED0;
      pass_count   <= '0;
      err_valid    <= 1'b0;
      err_addr     <= '0;
      err_expected <= '0;
      err_actual   <= '0;
    end else begin
      err_valid <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            phase      <= rand_only ? PH_RAND : PH_STUCK;
            sub        <= '0;
            offset     <= '0;
            seed       <= SEED0;
            pass_count <= '0;
            state      <= ST_FILL;
          end
          ST_FILL: if (sweep_last)
            state <= (phase == PH_ADDR) ? ST_MARK : ST_VERIFY;
          ST_MARK: state <= ST_VERIFY;
          ST_VERIFY: if (mismatch) begin
            err_valid    <= 1'b1;
            err_addr     <= sweep_addr;
            err_expected <= exp_val;
            err_actual   <= rd_data;
            state        <= ST_HOLD;
          end
          ST_HOLD: if (err_continue && !sweep_last) state <= ST_VERIFY;
          ST_CLEAR: begin
            if (walk_done) begin
              offset <= '0;
              state  <= ST_FILL;
              if (sub[0]) begin
                phase <= PH_RAND;
                sub   <= '0;
              end else begin
                sub <= 3'd1;
              end
            end else begin
              offset <= next_off;
              state  <= ST_MARK;
            end
          end
          default: state <= ST_IDLE;
        endcase

        if (verify_end) begin
          case (phase)
            PH_STUCK: begin
              state <= ST_FILL;
              if (sub[0]) begin phase <= PH_WALK1; sub <= '0; end
              else sub <= sub + 3'd1;
            end
            PH_WALK1: begin
              state <= ST_FILL;
              if (sub == 3'd7) begin phase <= PH_ADDR; sub <= '0; offset <= '0; end
              else sub <= sub + 3'd1;
            end
            PH_ADDR: state <= ST_CLEAR;
            default: begin
              seed       <= seed_fix(lfsr_next(lfsr_q));
              pass_count <= pass_count + PW'(1);
              state      <= ST_FILL;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int         ADDR_W    = 8,
  parameter int         PASS_W    = 16,
  parameter logic [7:0] RAND_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              rand_only,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [7:0]        rd_data,
  input  logic              err_continue,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [7:0]        err_expected,
  output logic [7:0]        err_actual,
  output logic [PASS_W-1:0] pass_count
);
  logic [ADDR_W-1:0] sweep_addr;
  logic              sweep_last, sweep_load, sweep_adv;
  logic              lfsr_load, lfsr_step;
  logic [7:0]        lfsr_seed, lfsr_q;
  logic              pass_done, mismatch;

  mt_sweep #(.AW(ADDR_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .load(sweep_load), .adv(sweep_adv),
    .first_addr(start_addr), .last_addr(end_addr),
    .addr(sweep_addr), .at_last(sweep_last)
  );

  mt_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .load_val(lfsr_seed),
    .step(lfsr_step), .state(lfsr_q)
  );

  mt_ctrl #(.AW(ADDR_W), .PW(PASS_W), .SEED0(RAND_SEED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rand_only(rand_only), .start_addr(start_addr), .end_addr(end_addr),
    .rd_data(rd_data), .err_continue(err_continue),
    .sweep_addr(sweep_addr), .sweep_last(sweep_last), .lfsr_q(lfsr_q),
    .sweep_load(sweep_load), .sweep_adv(sweep_adv),
    .lfsr_load(lfsr_load), .lfsr_seed(lfsr_seed), .lfsr_step(lfsr_step),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .busy(busy), .err_valid(err_valid), .err_addr(err_addr),
    .err_expected(err_expected), .err_actual(err_actual),
    .pass_count(pass_count), .pass_done(pass_done), .mismatch(mismatch)
  );
endmodule

// File: rtl/mt_checks.sv
module mt_checks #(
  parameter int AW = 8,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] end_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          busy,
  input logic          err_valid,
  input logic [PW-1:0] pass_count,
  input logic          pass_done,
  input logic          mismatch
);
  assert_we_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_addr >= start_addr && mem_addr <= end_addr));

  assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !mem_we));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  assert_err_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !mem_we);

  assert_mismatch_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !abort) |=> err_valid);

  assert_pass_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> (pass_count == $past(pass_count) + PW'(1)));

  assert_pass_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && pass_count != $past(pass_count))
      |-> (pass_count == $past(pass_count) + PW'(1)));
endmodule

bind memtest_engine mt_checks #(.AW(ADDR_W), .PW(PASS_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .abort(abort), .start_addr(start_addr),
  .end_addr(end_addr), .mem_addr(mem_addr), .mem_we(mem_we), .busy(busy),
  .err_valid(err_valid), .pass_count(pass_count), .pass_done(pass_done),
  .mismatch(mismatch)
);

// File: tb/tb_memtest_engine.sv
`timescale 1ns/1ps
module tb_memtest_engine;
  localparam int AW = 8;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, abort = 0, rand_only = 0, err_continue = 0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [7:0] rd_data;
  logic [AW-1:0] mem_addr, err_addr;
  logic [7:0] mem_wdata, err_expected, err_actual;
  logic mem_we, busy, err_valid;
  logic [PW-1:0] pass_count;

  always #10 clk = ~clk;

  memtest_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rand_only(rand_only), .start_addr(start_addr), .end_addr(end_addr),
    .rd_data(rd_data), .err_continue(err_continue), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy),
    .err_valid(err_valid), .err_addr(err_addr), .err_expected(err_expected),
    .err_actual(err_actual), .pass_count(pass_count)
  );

  // RAM model with an optional stuck-at-one fault
  logic [7:0] ram [256];
  logic [7:0] fault_addr = '0, fault_mask = '0;
  assign rd_data = ram[mem_addr] | ((mem_addr == fault_addr) ? fault_mask : 8'h00);
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0;
  int errs_seen = 0;
  logic [15:0] wq [$];
  logic [23:0] eq [$];
  logic [7:0]  ref_mem [256];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] prng(input logic [7:0] s);
    return {s[6:0], ^(s & 8'hB8)};
  endfunction

  task automatic rwr(input logic [7:0] a, input logic [7:0] d);
    ref_mem[a] = d;
    wq.push_back({a, d});
  endtask

  task automatic rchk(input logic [7:0] a, input logic [7:0] e);
    logic [7:0] v;
    v = ref_mem[a] | ((a == fault_addr) ? fault_mask : 8'h00);
    if (v != e) eq.push_back({a, e, v});
  endtask

  task automatic sweep_pattern(input int s, input int e, input logic [7:0] p);
    for (int a = s; a <= e; a++) rwr(a[7:0], p);
    for (int a = s; a <= e; a++) rchk(a[7:0], p);
  endtask

  // expected sequence, built from the requirements
  task automatic build_ref(input int s, input int e, input bit ro, input int npass);
    logic [7:0] seed, x, bgv, mkv;
    int off;
    wq.delete(); eq.delete();
    if (!ro) begin
      sweep_pattern(s, e, 8'hFF);                       // R2
      sweep_pattern(s, e, 8'h00);
      for (int k = 0; k < 8; k++) sweep_pattern(s, e, 8'(1 << k));  // R3
      for (int r = 0; r < 2; r++) begin                 // R4, R5
        bgv = r ? 8'hAA : 8'h55;
        mkv = r ? 8'h55 : 8'hAA;
        for (int a = s; a <= e; a++) rwr(a[7:0], bgv);
        off = 0;
        while (s + off <= e) begin
          rwr(8'(s + off), mkv);
          for (int a = s; a <= e; a++) rchk(a[7:0], (a == s + off) ? mkv : bgv);
          rwr(8'(s + off), bgv);
          off = (off == 0) ? 1 : off * 2;
        end
      end
    end
    seed = 8'hA5;                                       // R6, R9
    for (int n = 0; n <= npass; n++) begin
      x = seed;
      for (int a = s; a <= e; a++) begin rwr(a[7:0], x); x = prng(x); end
      if (n < npass) begin
        x = seed;
        for (int a = s; a <= e; a++) begin rchk(a[7:0], x); x = prng(x); end
        seed = (x == 8'h00) ? 8'h01 : x;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wq.size() == 0)
        check(0, "R10", "unexpected write at", int'(mem_addr), -1);
      else begin
        logic [15:0] w;
        w = wq.pop_front();
        check({mem_addr, mem_wdata} == w, "R10", "write {addr,data}",
              int'({mem_addr, mem_wdata}), int'(w));
      end
    end
    if (rst_n && err_valid) begin
      errs_seen++;
      if (eq.size() == 0)
        check(0, "R7", "unexpected report", int'({err_addr, err_expected, err_actual}), -1);
      else begin
        logic [23:0] r;
        r = eq.pop_front();
        check({err_addr, err_expected, err_actual} == r, "R7", "report {addr,exp,act}",
              int'({err_addr, err_expected, err_actual}), int'(r));
      end
    end
  end

  // report acknowledger: also checks the stall
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && err_valid) begin
        logic [AW-1:0] held;
        held = mem_addr;
        @(negedge clk);
        check(!mem_we && mem_addr == held, "R7", "stall while report pending",
              int'({mem_we, mem_addr}), int'({1'b0, held}));
        @(posedge clk); #2 err_continue = 1'b1;
        @(posedge clk); #2 err_continue = 1'b0;
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic kick(input int s, input int e, input bit ro);
    @(posedge clk); #2;
    start_addr = s[7:0]; end_addr = e[7:0]; rand_only = ro; start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic wait_pass(input int n, input string req);
    int t = 0;
    while (pass_count != PW'(n) && t < 30000) begin @(negedge clk); t++; end
    check(pass_count == PW'(n), req, "pass_count reached", int'(pass_count), n);
  endtask

  task automatic do_abort();
    @(posedge clk); #2 abort = 1'b1;
    @(posedge clk); #2 abort = 1'b0;
    @(negedge clk);
    check(!busy && !mem_we, "R8", "idle after abort", int'({busy, mem_we}), 0);
    wq.delete();
    repeat (10) @(negedge clk);
    check(!busy, "R8", "stays idle after abort", int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h3C;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mem_we && !err_valid && pass_count == 0, "R1", "state in reset",
          int'({busy, mem_we, err_valid, pass_count}), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mem_we && pass_count == 0, "R1", "idle after reset",
          int'({busy, mem_we}), 0);

    // full sequence on a good RAM: R2 R3 R4 R5 R6
    build_ref(16, 47, 0, 2);
    errs_seen = 0;
    kick(16, 47, 0);
    @(negedge clk);
    check(busy, "R1", "busy after start", int'(busy), 1);
    wait_pass(2, "R6");
    check(errs_seen == 0, "R2", "no reports on good RAM", errs_seen, 0);
    do_abort();

    // stuck-at-one bit 2 at 15h: R7
    fault_addr = 8'h15; fault_mask = 8'h04;
    build_ref(16, 47, 0, 1);
    errs_seen = 0;
    kick(16, 47, 0);
    wait_pass(1, "R7");
    check(eq.size() == 0, "R7", "all expected reports seen", eq.size(), 0);
    check(errs_seen > 7, "R7", "report count above 7", errs_seen, 8);
    do_abort();
    fault_mask = 8'h00;

    // random only: R9
    build_ref(64, 79, 1, 3);
    kick(64, 79, 1);
    @(negedge clk);
    check(mem_we && mem_addr == 8'h40 && mem_wdata == 8'hA5, "R9", "first write",
          int'({mem_addr, mem_wdata}), 16'h40A5);
    wait_pass(3, "R9");
    do_abort();

    // walk reaching the top of the address space: R4
    build_ref(224, 255, 0, 1);
    kick(224, 255, 0);
    wait_pass(1, "R4");
    do_abort();

    // abort mid-run, then restart: R8
    build_ref(16, 47, 0, 1);
    kick(16, 47, 0);
    repeat (300) @(negedge clk);
    do_abort();
    build_ref(16, 31, 1, 1);
    kick(16, 31, 1);
    wait_pass(1, "R8");
    check(pass_count == 1, "R1", "count restarted from zero", int'(pass_count), 1);
    do_abort();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule